// File: doc/BRIEF.md
# Basic Transfer Bus Master Sequencer

This block is the controlling-master side of a parallel system bus. It runs one basic transfer at a time. A request carries an address, a memory or I/O select, a read or write select, write data and a refresh marker. The block turns it into a fixed sequence of bus phases. The address group comes first. The cycle-type status pair follows one clock later, then the address latch strobe. The command strobe then takes over from the latch strobe, and status and address are withdrawn in turn. After that, the block waits for the selected slave's ready line before it ends the cycle.

Each phase lasts one clock. Read data is captured on the clock edge that raises the command strobe. A refresh request always runs as a memory read. The slave's ready line may hold the cycle for as long as it likes. If the hold runs past a parameterised clock count (3.0 µs at the default clock), a timeout flag goes up. The cycle still waits for the slave after the flag is set.

Top module: `basic_xfer_master`

## Requirements
- R1: After reset, and between cycles, `reqReady` is 1, `busAddr` is 0, `busMemIo` and `busNarrowAddr` are 0, `busRefreshN`, `busAdlN`, `busCmdN`, `busS0N` and `busS1N` are 1, and `busDataOe` is 0.
- R2: A request with `reqValid` high is accepted on a clock edge where `reqReady` is 1. In the next clock the address group is driven with status idle, `busAdlN` and `busCmdN` high, and `reqReady` low.
- R3: One clock after the address group, the status pair turns active (read: `busS0N`=0, `busS1N`=1; write: `busS0N`=1, `busS1N`=0). One clock after that, `busAdlN` goes low.
- R4: For a write, `busDataOut` carries the request data and `busDataOe` is 1 from the `busAdlN` phase until the cycle ends. For a read, `busDataOe` stays 0.
- R5: `busCmdN` falls in the same clock that `busAdlN` rises. One clock later status returns to idle (both 1) with the address still valid. One clock after that, the address group returns to its idle values.
- R6: Once the address is withdrawn, `busCmdN` stays low through every clock edge that samples `busReady` low. The cycle ends at the first edge that samples it high: `busCmdN` rises and `reqReady` returns to 1. With no waits, a cycle occupies six clocks.
- R7: On a plain read, `busDataIn` is captured at the edge that ends the cycle. It appears on `rdData`, and `rdValid` is high for that one clock. Writes and refreshes never raise `rdValid`.
- R8: `busNarrowAddr` is 1 while the address is driven if and only if the address is at most 0x00FFFFFF.
- R9: `busMemIo` is 1 for memory cycles and 0 for I/O cycles while the address is driven.
- R10: A refresh request drives `busRefreshN` low while the address is driven and runs a memory read, whatever `reqMem` and `reqWrite` say.
- R11: `waitTimeout` rises at the edge that takes the (WAIT_LIMIT+1)-th consecutive low `busReady` sample in the wait phase. It does not end the cycle. It stays set until the next request is accepted.
- R12: `reqValid` has no effect while `reqReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Request address |
| reqMem | input | 1 | 1 = memory, 0 = I/O |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| reqRefresh | input | 1 | Refresh cycle |
| reqReady | output | 1 | Idle, request can be accepted |
| busAddr | output | ADDR_W | Bus address |
| busMemIo | output | 1 | Memory (1) or I/O (0) |
| busNarrowAddr | output | 1 | Address within low 16 MB |
| busRefreshN | output | 1 | Refresh marker, active low |
| busS0N | output | 1 | Status bit 0, active low |
| busS1N | output | 1 | Status bit 1, active low |
| busAdlN | output | 1 | Address latch strobe, active low |
| busCmdN | output | 1 | Command strobe, active low |
| busDataOut | output | DATA_W | Write data to bus |
| busDataOe | output | 1 | Write data enable |
| busDataIn | input | DATA_W | Read data from bus |
| busReady | input | 1 | Slave ready, low extends the cycle |
| rdData | output | DATA_W | Captured read data |
| rdValid | output | 1 | Read data valid pulse |
| waitTimeout | output | 1 | Ready hold exceeded limit |

## Verification
The bench builds the block with WAIT_LIMIT set to 6 in place of the 150-clock default. That puts both sides of the timeout threshold within reach of short cycles: six low ready samples must leave the flag clear, and nine must raise it while the command strobe is still held. The default address and data widths are kept, so the address-range flag is tested at 0x00FFFFFF and 0x01000000.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_STAT, PH_ADL, PH_CMD, PH_STOFF, PH_HOLD
  } xferPhase_t;

  typedef struct packed {
    logic loadReq;
    logic addrOn;
    logic statusOn;
    logic adlOn;
    logic cmdOn;
    logic dataOn;
    logic capture;
    logic waitTick;
  } xferCtrl_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      busReady,
  output logic      reqReady,
  output xferCtrl_t ctrl
);
  xferPhase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    reqReady  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.loadReq = 1'b1;
          phaseNext    = PH_ADDR;
        end
      end
      PH_ADDR: begin
        ctrl.addrOn = 1'b1;
        phaseNext   = PH_STAT;
      end
      PH_STAT: begin
        ctrl.addrOn   = 1'b1;
        ctrl.statusOn = 1'b1;
        phaseNext     = PH_ADL;
      end
      PH_ADL: begin
        ctrl.addrOn   = 1'b1;
        ctrl.statusOn = 1'b1;
        ctrl.adlOn    = 1'b1;
        ctrl.dataOn   = 1'b1;
        phaseNext     = PH_CMD;
      end
      PH_CMD: begin
        ctrl.addrOn   = 1'b1;
        ctrl.statusOn = 1'b1;
        ctrl.cmdOn    = 1'b1;
        ctrl.dataOn   = 1'b1;
        phaseNext     = PH_STOFF;
      end
      PH_STOFF: begin
        ctrl.addrOn = 1'b1;
        ctrl.cmdOn  = 1'b1;
        ctrl.dataOn = 1'b1;
        phaseNext   = PH_HOLD;
      end
      PH_HOLD: begin
        ctrl.cmdOn  = 1'b1;
        ctrl.dataOn = 1'b1;
        if (busReady) begin
          ctrl.capture = 1'b1;
          phaseNext    = PH_IDLE;
        end else begin
          ctrl.waitTick = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAIT_LIMIT = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqMem,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqRefresh,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busMemIo,
  output logic              busNarrowAddr,
  output logic              busRefreshN,
  output logic              busS0N,
  output logic              busS1N,
  output logic              busAdlN,
  output logic              busCmdN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              waitTimeout
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam int HI_W  = ADDR_W - 24;
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(WAIT_LIMIT);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              memQ, writeQ, refreshQ;
  logic [CNT_W-1:0]  waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      memQ     <= 1'b0;
      writeQ   <= 1'b0;
      refreshQ <= 1'b0;
    end else if (ctrl.loadReq) begin
      addrQ    <= reqAddr;
      wdataQ   <= reqWdata;
      memQ     <= reqMem | reqRefresh;
      writeQ   <= reqWrite & ~reqRefresh;
      refreshQ <= reqRefresh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctrl.capture & ~writeQ & ~refreshQ;
      if (ctrl.capture) rdData <= busDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt     <= '0;
      waitTimeout <= 1'b0;
    end else if (ctrl.loadReq) begin
      waitCnt     <= '0;
      waitTimeout <= 1'b0;
    end else if (ctrl.waitTick) begin
      if (waitCnt == LIMIT_C) waitTimeout <= 1'b1;
      else                    waitCnt     <= waitCnt + 1'b1;
    end
  end

  always_comb begin
    busAddr       = ctrl.addrOn ? addrQ : '0;
    busMemIo      = ctrl.addrOn & memQ;
    busNarrowAddr = ctrl.addrOn & (addrQ[ADDR_W-1 -: HI_W] == '0);
    busRefreshN   = ~(ctrl.addrOn & refreshQ);
    busS0N        = ~ctrl.statusOn | writeQ;
    busS1N        = ~ctrl.statusOn | ~writeQ;
    busAdlN       = ~ctrl.adlOn;
    busCmdN       = ~ctrl.cmdOn;
    busDataOe     = ctrl.dataOn & writeQ;
    busDataOut    = busDataOe ? wdataQ : '0;
  end
endmodule

// File: rtl/basic_xfer_master.sv
module basic_xfer_master
  import xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CLK_MHZ    = 50,
  parameter int WAIT_LIMIT = 3 * CLK_MHZ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqMem,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqRefresh,
  output logic              reqReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busMemIo,
  output logic              busNarrowAddr,
  output logic              busRefreshN,
  output logic              busS0N,
  output logic              busS1N,
  output logic              busAdlN,
  output logic              busCmdN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              waitTimeout
);
  xferCtrl_t ctrl;

  xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busReady(busReady),
    .reqReady(reqReady), .ctrl(ctrl)
  );

  xfer_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_LIMIT(WAIT_LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqAddr(reqAddr), .reqMem(reqMem), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqRefresh(reqRefresh), .busDataIn(busDataIn),
    .busAddr(busAddr), .busMemIo(busMemIo), .busNarrowAddr(busNarrowAddr),
    .busRefreshN(busRefreshN), .busS0N(busS0N), .busS1N(busS1N),
    .busAdlN(busAdlN), .busCmdN(busCmdN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .rdData(rdData), .rdValid(rdValid),
    .waitTimeout(waitTimeout)
  );
endmodule

// File: rtl/basic_xfer_master_chk.sv
module basic_xfer_master_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic busMemIo,
  input logic busRefreshN,
  input logic busS0N,
  input logic busS1N,
  input logic busAdlN,
  input logic busCmdN,
  input logic busDataOe,
  input logic busReady,
  input logic rdValid
);
  // R2
  a_r2_accept_goes_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && busS0N && busS1N && busAdlN && busCmdN));
  // R3
  a_r3_adl_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    !busAdlN |-> (busS0N != busS1N));
  // R5
  a_r5_cmd_takes_over_adl: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCmdN) |-> (busAdlN && $past(!busAdlN)));
  // R6
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busCmdN && !busReady && $past(!busCmdN) && $past(busS0N && busS1N)) |=> !busCmdN);
  // R6
  a_r6_end_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCmdN) |-> $past(busReady));
  // R7
  a_r7_valid_at_end: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $rose(busCmdN));
  // R10
  a_r10_refresh_mem_read: assert property (@(posedge clk) disable iff (!rstN)
    !busRefreshN |-> (busMemIo && !busDataOe));
endmodule

bind basic_xfer_master basic_xfer_master_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busMemIo(busMemIo), .busRefreshN(busRefreshN), .busS0N(busS0N),
  .busS1N(busS1N), .busAdlN(busAdlN), .busCmdN(busCmdN),
  .busDataOe(busDataOe), .busReady(busReady), .rdValid(rdValid)
);

// File: tb/sim_basic_xfer_master.sv
`timescale 1ns/1ps
module sim_basic_xfer_master;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LIM = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqMem = 1'b0, reqWrite = 1'b0, reqRefresh = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0, busDataIn = '0;
  logic busReady = 1'b1;
  logic reqReady, busMemIo, busNarrowAddr, busRefreshN, busS0N, busS1N;
  logic busAdlN, busCmdN, busDataOe, rdValid, waitTimeout;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDataOut, rdData;

  int nChecks = 0;
  int nFail = 0;
  logic [DW-1:0] expQ[$];

  always #10 clk = ~clk;

  basic_xfer_master #(.ADDR_W(AW), .DATA_W(DW), .WAIT_LIMIT(LIM)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqMem(reqMem), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .reqRefresh(reqRefresh), .reqReady(reqReady), .busAddr(busAddr),
    .busMemIo(busMemIo), .busNarrowAddr(busNarrowAddr),
    .busRefreshN(busRefreshN), .busS0N(busS0N), .busS1N(busS1N),
    .busAdlN(busAdlN), .busCmdN(busCmdN), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn), .busReady(busReady),
    .rdData(rdData), .rdValid(rdValid), .waitTimeout(waitTimeout)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(reqReady && busAddr == '0 && !busMemIo && !busNarrowAddr && busRefreshN &&
        busS0N && busS1N && busAdlN && busCmdN && !busDataOe, req,
        {reqReady, busMemIo, busNarrowAddr, busRefreshN, busS0N, busS1N, busAdlN, busCmdN, busDataOe},
        9'b1_0_0_1_1_1_1_1_0);
  endtask

  // scoreboard monitor: compares every read result against the queue
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk(1'b0, "R7 unexpected rdValid", rdData, 0);
      else begin
        logic [DW-1:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R7 read data", rdData, e);
      end
    end
  end

  task automatic runXfer(input logic [AW-1:0] a, input bit mem, input bit wr,
                         input logic [DW-1:0] wd, input bit rf,
                         input logic [DW-1:0] rd, input int waitN, input bit poke);
    bit expMem, expWr, expNarrow;
    expMem    = mem | rf;
    expWr     = wr & ~rf;
    expNarrow = (a <= 32'h00FF_FFFF);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqMem = mem; reqWrite = wr; reqWdata = wd;
    reqRefresh = rf; busReady = (waitN == 0); busDataIn = rd;
    if (!expWr && !rf) expQ.push_back(rd);
    @(negedge clk);
    reqValid = 1'b0;
    // address phase
    chk(busAddr == a && !reqReady && busS0N && busS1N && busAdlN && busCmdN,
        "R2 address phase", busAddr, a);
    chk(busMemIo == expMem, "R9 mem/io select", busMemIo, expMem);
    chk(busNarrowAddr == expNarrow, "R8 narrow address flag", busNarrowAddr, expNarrow);
    chk(busRefreshN == !rf, "R10 refresh marker", busRefreshN, !rf);
    chk(waitTimeout == 1'b0, "R11 flag cleared on accept", waitTimeout, 0);
    @(negedge clk);
    chk(busS0N == expWr && busS1N == !expWr && busAdlN && busAddr == a,
        "R3 status phase", {busS0N, busS1N}, {expWr, !expWr});
    @(negedge clk);
    chk(!busAdlN && busCmdN && busS0N == expWr, "R3 latch strobe phase", busAdlN, 0);
    chk(busDataOe == expWr && busDataOut == (expWr ? wd : '0),
        "R4 write data before command", busDataOut, expWr ? wd : '0);
    @(negedge clk);
    chk(!busCmdN && busAdlN && busS0N == expWr && busAddr == a,
        "R5 command replaces latch strobe", {busCmdN, busAdlN}, 2'b01);
    @(negedge clk);
    chk(!busCmdN && busS0N && busS1N && busAddr == a && busRefreshN == !rf,
        "R5 status withdrawn", {busS0N, busS1N}, 2'b11);
    @(negedge clk);
    chk(!busCmdN && busAddr == '0 && !busMemIo && busRefreshN && busDataOe == expWr,
        "R5 address withdrawn", busAddr, 0);
    for (int i = 0; i < waitN; i++) begin
      if (poke && i == 0) begin
        reqValid = 1'b1; reqAddr = 32'h0BAD_0000; reqWrite = 1'b1;
      end
      @(negedge clk);
      chk(!busCmdN && !reqReady, "R6 held by ready", busCmdN, 0);
      if (poke) chk(busAddr == '0 && busS0N && busS1N, "R12 busy request ignored", busAddr, 0);
    end
    reqValid = 1'b0;
    if (waitN > LIM) chk(waitTimeout == 1'b1 && !busCmdN, "R11 flag set while still waiting", waitTimeout, 1);
    if (waitN > 0 && waitN <= LIM) chk(waitTimeout == 1'b0, "R11 no flag at limit", waitTimeout, 0);
    busReady = 1'b1;
    @(negedge clk);
    chkIdle("R6 cycle ended");
    chk(waitTimeout == (waitN > LIM), "R11 flag after cycle", waitTimeout, waitN > LIM);
    @(negedge clk);
    chkIdle(poke ? "R12 no cycle from busy request" : "R1 idle between cycles");
    chk(!rdValid, "R7 single pulse", rdValid, 0);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 reset state");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset release");
    runXfer(32'h0012_3456, 1, 0, '0, 0, 32'hCAFE_0001, 0, 0);           // memory read
    runXfer(32'h0100_0000, 1, 1, 32'hA5A5_5A5A, 0, '0, 2, 0);          // write above 16 MB
    runXfer(32'h0000_03F8, 0, 0, '0, 0, 32'h0000_00EE, 0, 0);          // I/O read
    runXfer(32'h0000_01FF, 0, 1, 32'h1111_2222, 1, 32'h7777_7777, 1, 0); // refresh
    runXfer(32'h00FF_FFFF, 1, 0, '0, 0, 32'h1234_5678, LIM, 0);        // wait at limit
    runXfer(32'h0040_0000, 1, 0, '0, 0, 32'h8765_4321, LIM + 3, 1);    // timeout + busy poke
    runXfer(32'h0000_0010, 0, 1, 32'h0000_BEEF, 0, '0, 0, 0);          // I/O write, flag clears
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R7 all reads returned", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule